// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time and date for a chip: seconds, minutes, hours, a free-running day of the week, day of the month, month and a three-digit year. Each pulse on a one-second strobe input, taken while the clock enable is high, moves the time on by one second. The carry runs through the whole chain. Month lengths follow the usual calendar, and February gains a day under the full Gregorian leap-year rule. That rule is applied to a full year formed from a configurable century base plus the three-digit count.

Every field appears on its own BCD output and can be read through a field-select read mux. Fields are loaded one at a time through a write port that takes BCD data. A load is accepted only while the clock enable is high. The strobe comes from a prescaler outside the block.

Top module: `bcd_calendar`

## Requirements
- R1: While enabled, a strobe with no write in the same cycle advances the seconds. Seconds past 59 return to 0 and carry into minutes, minutes past 59 return to 0 and carry into hours, and hours past 23 return to 0.
- R2: An hour wrap advances both the weekday and the day of month. The weekday counts 0 to 6, then returns to 0.
- R3: With year base 1900 and a non-leap year, the day of month rolls over after 31 days in months 1, 3, 5, 7, 8, 10 and 12, after 30 days in months 4, 6, 9 and 11, and after 28 days in month 2.
- R4: February has 29 days when the full year (CENTURY_BASE plus the three-digit year) is a multiple of 4 and not of 100, or is a multiple of 400. With base 1900, years 096 and 100 are leap, and years 099 and 200 are not.
- R5: When the day passes the month length it returns to 1 and the month advances. Month 12 is followed by month 1 together with a year increment, and year 999 is followed by year 000.
- R6: Outputs and write data are BCD. Month is 01 to 12. The year uses bits [11:8] for the hundreds digit and bits [7:0] for tens and units. The field-select codes are 0 second, 1 minute, 2 hour, 3 weekday, 4 day of month, 5 month, 6 year and 7 none.
- R7: A write while clk_en is low leaves every field unchanged.
- R8: A write changes only the selected field. A write in the same cycle as a strobe wins: the written field takes the new value, every other field holds, and that second is dropped.
- R9: A strobe while clk_en is low does not advance the time.
- R10: After reset the time is 00:00:00, weekday 0, day 01, month 01, year 000.
- R11: rd_data returns the BCD value of the field chosen by rd_sel, zero-extended to 12 bits, and returns 0 for code 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Counter enable; gates both the strobe and writes |
| sec_strobe | input | 1 | One-cycle pulse marking one elapsed second |
| wr_en | input | 1 | Field write request |
| wr_sel | input | 3 | Field code for the write |
| wr_data | input | 12 | BCD write data |
| rd_sel | input | 3 | Field code for the read mux |
| rd_data | output | 12 | BCD value of the selected field |
| sec_bcd | output | 8 | Seconds, BCD |
| min_bcd | output | 8 | Minutes, BCD |
| hour_bcd | output | 8 | Hours, BCD |
| wday_bcd | output | 4 | Weekday 0 to 6 |
| mday_bcd | output | 8 | Day of month, BCD |
| mon_bcd | output | 8 | Month 01 to 12, BCD |
| year_bcd | output | 12 | Three-digit year, BCD |

## Verification
Every strobe or write sampled at a rising edge shows up on the field outputs right after that edge. The outputs settle one register stage after the stimulus, and rd_data follows rd_sel combinationally with no register in between. The driver applies each stimulus for exactly one edge and then queues the expected snapshot. The monitor compares that snapshot at the next falling edge, halfway between that edge and the following one. Read-mux checks change rd_sel at a falling edge and sample a short delay later, while the time is held still.

// File: rtl/bcd_calendar_pkg.sv
package bcd_calendar_pkg;

    localparam int SEC_LAST  = 59;
    localparam int MIN_LAST  = 59;
    localparam int HOUR_LAST = 23;
    localparam int WDAY_LAST = 6;
    localparam int MON_LAST  = 12;
    localparam int YEAR_LAST = 999;

    typedef enum logic [2:0] {
        FLD_SEC  = 3'd0,
        FLD_MIN  = 3'd1,
        FLD_HOUR = 3'd2,
        FLD_WDAY = 3'd3,
        FLD_MDAY = 3'd4,
        FLD_MON  = 3'd5,
        FLD_YEAR = 3'd6,
        FLD_NONE = 3'd7
    } cal_field_e;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic [2:0] wday;
        logic [5:0] mday;
        logic [4:0] mon;
        logic [9:0] year;
    } cal_time_t;

    localparam cal_time_t CAL_RESET = '{sec: 7'd0, min: 7'd0, hour: 6'd0,
                                        wday: 3'd0, mday: 6'd1, mon: 5'd1,
                                        year: 10'd0};

    function automatic logic [6:0] bcd_to_bin(input logic [7:0] d);
        return 7'(d[7:4]) * 7'd10 + 7'(d[3:0]);
    endfunction

    function automatic logic [7:0] bin_to_bcd(input logic [6:0] v);
        logic [6:0] tens;
        logic [6:0] units;
        tens  = v / 7'd10;
        units = v % 7'd10;
        return {tens[3:0], units[3:0]};
    endfunction

    function automatic logic [11:0] year_to_bcd(input logic [9:0] y);
        logic [9:0] hund;
        logic [9:0] rest;
        hund = y / 10'd100;
        rest = y % 10'd100;
        return {hund[3:0], bin_to_bcd(rest[6:0])};
    endfunction

    function automatic logic [4:0] base_days(input logic [4:0] mon);
        case (mon)
            5'd2:                      return 5'd28;
            5'd4, 5'd6, 5'd9, 5'd11:   return 5'd30;
            default:                   return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/cal_month_len.sv
module cal_month_len
    import bcd_calendar_pkg::*;
#(
    parameter int CENTURY_BASE = 1900
) (
    input  logic [4:0] mon,
    input  logic [9:0] year,
    output logic [4:0] days
);
    localparam logic [15:0] BASE16 = 16'(CENTURY_BASE);

    logic [15:0] full_year;
    logic        leap;

    always_comb begin
        full_year = BASE16 + 16'(year);
        leap = ((full_year % 16'd4) == 16'd0) &&
               (((full_year % 16'd100) != 16'd0) || ((full_year % 16'd400) == 16'd0));
        days = base_days(mon);
        if (mon == 5'd2 && leap) days = 5'd29;
    end
endmodule

// File: rtl/cal_carry.sv
module cal_carry
    import bcd_calendar_pkg::*;
(
    input  cal_time_t  cur,
    input  logic [4:0] month_days,
    output cal_time_t  nxt
);
    always_comb begin
        nxt = cur;
        if (cur.sec >= 7'(SEC_LAST)) begin
            nxt.sec = '0;
            if (cur.min >= 7'(MIN_LAST)) begin
                nxt.min = '0;
                if (cur.hour >= 6'(HOUR_LAST)) begin
                    nxt.hour = '0;
                    nxt.wday = (cur.wday >= 3'(WDAY_LAST)) ? 3'd0 : cur.wday + 3'd1;
                    if (cur.mday >= {1'b0, month_days}) begin
                        nxt.mday = 6'd1;
                        if (cur.mon >= 5'(MON_LAST)) begin
                            nxt.mon  = 5'd1;
                            nxt.year = (cur.year >= 10'(YEAR_LAST)) ? 10'd0 : cur.year + 10'd1;
                        end else begin
                            nxt.mon = cur.mon + 5'd1;
                        end
                    end else begin
                        nxt.mday = cur.mday + 6'd1;
                    end
                end else begin
                    nxt.hour = cur.hour + 6'd1;
                end
            end else begin
                nxt.min = cur.min + 7'd1;
            end
        end else begin
            nxt.sec = cur.sec + 7'd1;
        end
    end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import bcd_calendar_pkg::*;
#(
    parameter int CENTURY_BASE = 1900
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clk_en,
    input  logic        sec_strobe,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [11:0] wr_data,
    input  logic [2:0]  rd_sel,
    output logic [11:0] rd_data,
    output logic [7:0]  sec_bcd,
    output logic [7:0]  min_bcd,
    output logic [7:0]  hour_bcd,
    output logic [3:0]  wday_bcd,
    output logic [7:0]  mday_bcd,
    output logic [7:0]  mon_bcd,
    output logic [11:0] year_bcd
);
    cal_time_t  t_q;
    cal_time_t  t_next;
    logic [4:0] month_days;
    logic [6:0] ld_bin;
    logic [9:0] ld_year;
    logic       advance;

    cal_month_len #(.CENTURY_BASE(CENTURY_BASE)) u_len (
        .mon  (t_q.mon),
        .year (t_q.year),
        .days (month_days)
    );

    cal_carry u_carry (
        .cur        (t_q),
        .month_days (month_days),
        .nxt        (t_next)
    );

    assign ld_bin  = bcd_to_bin(wr_data[7:0]);
    assign ld_year = 10'(wr_data[11:8]) * 10'd100 + 10'(ld_bin);
    assign advance = clk_en && sec_strobe && !wr_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            t_q <= CAL_RESET;
        end else if (clk_en) begin
            if (wr_en) begin
                case (cal_field_e'(wr_sel))
                    FLD_SEC:  t_q.sec  <= ld_bin;
                    FLD_MIN:  t_q.min  <= ld_bin;
                    FLD_HOUR: t_q.hour <= ld_bin[5:0];
                    FLD_WDAY: t_q.wday <= ld_bin[2:0];
                    FLD_MDAY: t_q.mday <= ld_bin[5:0];
                    FLD_MON:  t_q.mon  <= ld_bin[4:0];
                    FLD_YEAR: t_q.year <= ld_year;
                    default:  t_q      <= t_q;
                endcase
            end else if (sec_strobe) begin
                t_q <= t_next;
            end
        end
    end

    assign sec_bcd  = bin_to_bcd(t_q.sec);
    assign min_bcd  = bin_to_bcd(t_q.min);
    assign hour_bcd = bin_to_bcd({1'b0, t_q.hour});
    assign wday_bcd = {1'b0, t_q.wday};
    assign mday_bcd = bin_to_bcd({1'b0, t_q.mday});
    assign mon_bcd  = bin_to_bcd({2'b0, t_q.mon});
    assign year_bcd = year_to_bcd(t_q.year);

    always_comb begin
        case (cal_field_e'(rd_sel))
            FLD_SEC:  rd_data = {4'd0, sec_bcd};
            FLD_MIN:  rd_data = {4'd0, min_bcd};
            FLD_HOUR: rd_data = {4'd0, hour_bcd};
            FLD_WDAY: rd_data = {8'd0, wday_bcd};
            FLD_MDAY: rd_data = {4'd0, mday_bcd};
            FLD_MON:  rd_data = {4'd0, mon_bcd};
            FLD_YEAR: rd_data = year_bcd;
            default:  rd_data = 12'd0;
        endcase
    end

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (rst)
        advance && t_q.sec == 7'd59 |=> t_q.sec == 7'd0); // R1
    AST_MIN_CARRY: assert property (@(posedge clk) disable iff (rst)
        advance && t_q.sec == 7'd59 && t_q.min < 7'd59 |=> t_q.min == $past(t_q.min) + 7'd1); // R1
    AST_DAY_ROLL: assert property (@(posedge clk) disable iff (rst)
        advance && t_q.sec == 7'd59 && t_q.min == 7'd59 && t_q.hour == 6'd23
        |=> t_q.hour == 6'd0 && t_q.wday != $past(t_q.wday)); // R2
    AST_MONTH_ROLL: assert property (@(posedge clk) disable iff (rst)
        advance && t_q.sec == 7'd59 && t_q.min == 7'd59 && t_q.hour == 6'd23
        && t_q.mday == {1'b0, month_days} |=> t_q.mday == 6'd1); // R5
    AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (rst)
        advance && t_q.sec == 7'd59 && t_q.min == 7'd59 && t_q.hour == 6'd23
        && t_q.mday == {1'b0, month_days} && t_q.mon == 5'd12 && t_q.year == 10'd999
        |=> t_q.year == 10'd0 && t_q.mon == 5'd1); // R5
    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> $stable(t_q)); // R7
    AST_LOAD_ISOLATE: assert property (@(posedge clk) disable iff (rst)
        clk_en && wr_en && wr_sel != 3'd1 |=> $stable(t_q.min)); // R8
endmodule

// File: tb/bcd_calendar_tb.sv
`timescale 1ns/1ps
module bcd_calendar_tb;
    localparam int BASE = 1900;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clk_en = 1'b0;
    logic        sec_strobe = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = 3'd7;
    logic [11:0] wr_data = 12'd0;
    logic [2:0]  rd_sel = 3'd7;
    logic [11:0] rd_data;
    logic [7:0]  sec_bcd, min_bcd, hour_bcd, mday_bcd, mon_bcd;
    logic [3:0]  wday_bcd;
    logic [11:0] year_bcd;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    int m_sec, m_min, m_hour, m_wday, m_mday, m_mon, m_year;

    string       tag_q[$];
    logic [55:0] exp_q[$];

    always #4 clk = ~clk;

    bcd_calendar #(.CENTURY_BASE(BASE)) u_dut (
        .clk(clk), .rst(rst), .clk_en(clk_en), .sec_strobe(sec_strobe),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .sec_bcd(sec_bcd), .min_bcd(min_bcd),
        .hour_bcd(hour_bcd), .wday_bcd(wday_bcd), .mday_bcd(mday_bcd),
        .mon_bcd(mon_bcd), .year_bcd(year_bcd)
    );

    function automatic logic [7:0] b8(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int from_b8(input logic [7:0] d);
        return int'(d[7:4]) * 10 + int'(d[3:0]);
    endfunction

    function automatic int mlen(input int mo, input int yr);
        int fy;
        bit lp;
        fy = BASE + yr;
        lp = (fy % 400 == 0) || ((fy % 4 == 0) && (fy % 100 != 0));
        case (mo)
            2:           return lp ? 29 : 28;
            4, 6, 9, 11: return 30;
            default:     return 31;
        endcase
    endfunction

    function automatic logic [55:0] snapshot();
        return {b8(m_sec), b8(m_min), b8(m_hour), 4'(m_wday), b8(m_mday),
                b8(m_mon), 4'(m_year / 100), b8(m_year % 100)};
    endfunction

    task automatic model_tick();
        m_sec++;
        if (m_sec >= 60) begin
            m_sec = 0; m_min++;
            if (m_min >= 60) begin
                m_min = 0; m_hour++;
                if (m_hour >= 24) begin
                    m_hour = 0;
                    m_wday = (m_wday + 1) % 7;
                    m_mday++;
                    if (m_mday > mlen(m_mon, m_year)) begin
                        m_mday = 1; m_mon++;
                        if (m_mon > 12) begin
                            m_mon = 1;
                            m_year = (m_year + 1) % 1000;
                        end
                    end
                end
            end
        end
    endtask

    task automatic model_write(input int sel, input logic [11:0] d);
        case (sel)
            0: m_sec  = from_b8(d[7:0]);
            1: m_min  = from_b8(d[7:0]);
            2: m_hour = from_b8(d[7:0]);
            3: m_wday = from_b8(d[7:0]);
            4: m_mday = from_b8(d[7:0]);
            5: m_mon  = from_b8(d[7:0]);
            6: m_year = int'(d[11:8]) * 100 + from_b8(d[7:0]);
            default: ;
        endcase
    endtask

    // Driver: one-edge stimulus, then queue the expected snapshot.
    task automatic op(input string tag, input bit en, input bit stb,
                      input bit we, input int sel, input logic [11:0] d);
        @(negedge clk);
        clk_en = en; sec_strobe = stb; wr_en = we; wr_sel = 3'(sel); wr_data = d;
        @(posedge clk);
        #1;
        sec_strobe = 1'b0; wr_en = 1'b0;
        if (en) begin
            if (we) model_write(sel, d);
            else if (stb) model_tick();
        end
        tag_q.push_back(tag);
        exp_q.push_back(snapshot());
    endtask

    task automatic wr(input string tag, input int sel, input logic [11:0] d);
        op(tag, 1'b1, 1'b0, 1'b1, sel, d);
    endtask

    task automatic tick(input string tag);
        op(tag, 1'b1, 1'b1, 1'b0, 7, 12'd0);
    endtask

    task automatic set_eod(input string tag, input int mo, input int md, input logic [11:0] yr);
        wr(tag, 6, yr);
        wr(tag, 5, b8(mo));
        wr(tag, 4, b8(md));
        wr(tag, 2, 12'h023);
        wr(tag, 1, 12'h059);
        wr(tag, 0, 12'h059);
    endtask

    task automatic rd_chk(input string tag, input int sel, input logic [11:0] exp);
        @(negedge clk);
        rd_sel = 3'(sel);
        #1;
        checks++;
        if (rd_data !== exp) begin
            failures++;
            $display("FAIL %s: rd_data actual=%h expected=%h", tag, rd_data, exp);
        end
    endtask

    // Monitor: compare queued expectations half a cycle after the update.
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            string       tg;
            logic [55:0] ex;
            logic [55:0] act;
            tg = tag_q.pop_front();
            ex = exp_q.pop_front();
            act = {sec_bcd, min_bcd, hour_bcd, wday_bcd, mday_bcd, mon_bcd, year_bcd};
            checks++;
            if (act !== ex) begin
                failures++;
                $display("FAIL %s: actual=%h expected=%h", tg, act, ex);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m_sec = 0; m_min = 0; m_hour = 0; m_wday = 0; m_mday = 1; m_mon = 1; m_year = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        op("R10 reset state", 1'b0, 1'b0, 1'b0, 7, 12'd0);
        op("R7 write while disabled", 1'b0, 1'b0, 1'b1, 0, 12'h045);
        op("R7 year write while disabled", 1'b0, 1'b0, 1'b1, 6, 12'h321);
        op("R9 strobe while disabled", 1'b0, 1'b1, 1'b0, 7, 12'd0);
        tick("R9 strobe while enabled");
        wr("R8 hour load only", 2, 12'h017);
        wr("R1 load sec", 0, 12'h058);
        tick("R1 sec 58 to 59");
        tick("R1 sec wrap carries minute");
        wr("R1 load min", 1, 12'h059);
        wr("R1 load sec", 0, 12'h059);
        tick("R1 minute wrap carries hour");
        // R2 weekday wrap at day end
        wr("R2 load wday", 3, 12'h006);
        set_eod("R2 setup", 3, 14, 12'h023);
        tick("R2 hour wrap advances weekday and day");
        // R3 month lengths, non-leap year 1923
        for (int mo = 1; mo <= 12; mo++) begin
            set_eod("R3 setup", mo, mlen(mo, 23), 12'h023);
            tick($sformatf("R3 month %0d rollover", mo));
        end
        // R4 leap years
        set_eod("R4 setup 2000", 2, 28, 12'h100);
        tick("R4 year 2000 Feb 28 to 29");
        wr("R4 load sec", 0, 12'h059); wr("R4 load min", 1, 12'h059); wr("R4 load hour", 2, 12'h023);
        tick("R4 year 2000 Feb 29 to Mar 1");
        set_eod("R4 setup 2100", 2, 28, 12'h200);
        tick("R4 year 2100 Feb 28 to Mar 1");
        set_eod("R4 setup 1996", 2, 28, 12'h096);
        tick("R4 year 1996 Feb 28 to 29");
        set_eod("R4 setup 1999", 2, 28, 12'h099);
        tick("R4 year 1999 Feb 28 to Mar 1");
        // R5 year carries
        set_eod("R5 setup", 12, 31, 12'h099);
        tick("R5 Dec 31 year 099 to 100");
        set_eod("R5 setup", 12, 31, 12'h999);
        tick("R5 year 999 wraps to 000");
        // R8 write wins over strobe
        wr("R8 load sec", 0, 12'h059);
        op("R8 write beats strobe", 1'b1, 1'b1, 1'b1, 0, 12'h030);
        wr("R6 month BCD 12", 5, 12'h012);
        wr("R6 year BCD 3 digits", 6, 12'h487);
        // R11 read mux
        @(negedge clk);
        clk_en = 1'b0;
        rd_chk("R11 sec", 0, {4'd0, b8(m_sec)});
        rd_chk("R11 min", 1, {4'd0, b8(m_min)});
        rd_chk("R11 hour", 2, {4'd0, b8(m_hour)});
        rd_chk("R11 wday", 3, 12'(m_wday));
        rd_chk("R11 mday", 4, {4'd0, b8(m_mday)});
        rd_chk("R11 month", 5, {4'd0, b8(m_mon)});
        rd_chk("R11 year", 6, 12'h487);
        rd_chk("R11 none", 7, 12'h000);
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule